// File: doc/BRIEF.md
# Triangle-Wave Counter for Complementary PWM

This block is an up/down timer that traces a triangle wave, as used to drive complementary PWM stages. Software programs a peak value `m` and, for each of three channels, a buffered duty value. While counting is enabled, the counter climbs from zero until it reaches `m + 1`, one step past the peak, then turns and descends back to zero, where it turns upward again. The step from `m` to `m + 1` is the peak event. It sets a sticky compare-match flag, which software clears. When the transfer-mode input selects it, the same event also copies every buffered duty value into the active duty value that downstream comparators use.

Duty values are updated in the middle of a PWM period by writing the buffers at any time. The active values then change together, once per period, at the peak. The descending pass through `m` never raises the flag and never moves data.

The register port is a plain one-cycle write strobe with a combinational read path. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure: a write always completes on the clock edge at which `wr_en` is high.

Top module: `tri_pwm_counter`

## Requirements
- R1: While enabled, the count rises by one per cycle up to `m + 1`, where `m` is the peak register, and then falls by one per cycle. Around the top the values are `m-1, m, m+1, m, m-1`.
- R2: With `cnt_en` low, the count and its direction hold their values.
- R3: `cmp_flag` becomes 1 on the edge where the count steps from `m` to `m + 1`, so it is visible in the same cycle that the count reads `m + 1`. On the descending steps it keeps its value.
- R4: When `xfer_mode` equals 2'b11, the peak event copies each buffer into its active duty value on that same edge. Channel `i` appears on `duty_o[i*W +: W]`.
- R5: No active duty value changes while the counter is descending, including its pass through `m`.
- R6: Writing data with bit 0 equal to 0 to address 1 (status) clears `cmp_flag`. Writing 1 there has no effect. Status reads return the flag in bit 0.
- R7: When the descending count reaches 0, the next enabled step goes to 1 and the counter counts upward again.
- R8: A buffer write (addresses 4, 5, 6 for channels 0, 1, 2) reads back on the next cycle. The active values, readable at addresses 8, 9, 10, change only at a transfer.
- R9: With `xfer_mode` other than 2'b11, the peak event still sets `cmp_flag` but moves no buffer.
- R10: When a status clear and a peak event fall on the same edge, `cmp_flag` ends at 1.
- R11: A write to the peak register (address 0) saturates at 2^W − 2. Address 0 reads back the stored value.
- R12: After reset, the count is 0 and the direction is upward. The flag, the peak, the buffers and the active values are all 0.
- R13: Address 2 reads the current count. Unmapped read addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable |
| xfer_mode | input | 2 | Transfer mode; 2'b11 enables buffer-to-active copy at the peak |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | W | Register read data (combinational) |
| count_o | output | W | Current count |
| peak_o | output | W | Stored peak value |
| cmp_flag | output | 1 | Sticky compare-match flag |
| duty_o | output | NUM_CH*W | Active duty values, channel 0 in the low bits |

## Verification
A wrong direction bit shows on `count_o` within one enabled cycle, as a step the wrong way or a missed turn at `m + 1` or 0. A mis-timed peak event shows as `cmp_flag` rising in a cycle where `count_o` is not `m + 1`. It can also show as `duty_o` moving while the count falls. Both appear on the edge that commits the event. Stale buffer or active state is exposed at the next peak or by reading back through the register port, so every such fault surfaces within one triangle period.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int ADDR_W    = 4;
  localparam int ADDR_PEAK = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CNT  = 2;
  localparam int BUF_BASE  = 4;
  localparam int ACT_BASE  = 8;
  localparam logic [1:0] XFER_ON = 2'b11;
endpackage

// File: rtl/tpc_updown.sv
// Triangle counter core: rises to peak+1, falls to zero, repeats.
module tpc_updown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] peak,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         hit
);
  logic [W:0] turn;
  logic       step_up;

  assign turn = {1'b0, peak} + {{W{1'b0}}, 1'b1};

  always_comb begin
    if (dir_up) step_up = ({1'b0, count} < turn);
    else        step_up = (count == '0);
  end

  // peak event: an upward step that leaves m
  assign hit = en && step_up && (count == peak);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (en) begin
      if (step_up) begin
        count  <= count + 1'b1;
        dir_up <= 1'b1;
      end else begin
        count  <= count - 1'b1;
        dir_up <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpc_flag.sv
// Sticky compare-match flag; set has priority over software clear.
module tpc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tpc_chan.sv
// One duty channel: software-written buffer plus active copy.
module tpc_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wd,
  input  logic         load,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_we) buf_q <= buf_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= buf_q;
  end
endmodule

// File: rtl/tri_pwm_counter.sv
module tri_pwm_counter
  import tpc_pkg::*;
#(
  parameter int W      = 16,
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic [1:0]          xfer_mode,
  input  logic                wr_en,
  input  logic [3:0]          wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic [3:0]          rd_addr,
  output logic [W-1:0]        rd_data,
  output logic [W-1:0]        count_o,
  output logic [W-1:0]        peak_o,
  output logic                cmp_flag,
  output logic [NUM_CH*W-1:0] duty_o
);
  localparam logic [W-1:0] PEAK_MAX = {{(W-1){1'b1}}, 1'b0};

  logic                peak_q;
  logic [W-1:0]        peak_r;
  logic                dir_up;
  logic                hit;
  logic                xfer;
  logic                stat_clr;
  logic [NUM_CH*W-1:0] buf_flat;
  logic [W-1:0]        buf_arr [NUM_CH];
  logic [W-1:0]        act_arr [NUM_CH];

  assign peak_q = wr_en && (wr_addr == ADDR_W'(ADDR_PEAK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      peak_r <= '0;
    else if (peak_q) peak_r <= (wr_data > PEAK_MAX) ? PEAK_MAX : wr_data;
  end
  assign peak_o = peak_r;

  tpc_updown #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cnt_en),
    .peak   (peak_r),
    .count  (count_o),
    .dir_up (dir_up),
    .hit    (hit)
  );

  assign stat_clr = wr_en && (wr_addr == ADDR_W'(ADDR_STAT)) && !wr_data[0];
  assign xfer     = hit && (xfer_mode == XFER_ON);

  tpc_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (stat_clr),
    .flag  (cmp_flag)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic we;
    assign we = wr_en && (wr_addr == ADDR_W'(BUF_BASE + i));
    tpc_chan #(.W(W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .buf_we (we),
      .buf_wd (wr_data),
      .load   (xfer),
      .buf_q  (buf_arr[i]),
      .act_q  (act_arr[i])
    );
    assign duty_o[i*W +: W]   = act_arr[i];
    assign buf_flat[i*W +: W] = buf_arr[i];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_PEAK)) rd_data = peak_r;
    if (rd_addr == ADDR_W'(ADDR_STAT)) rd_data = {{(W-1){1'b0}}, cmp_flag};
    if (rd_addr == ADDR_W'(ADDR_CNT))  rd_data = count_o;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(BUF_BASE + i)) rd_data = buf_arr[i];
      if (rd_addr == ADDR_W'(ACT_BASE + i)) rd_data = act_arr[i];
    end
  end
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker
  import tpc_pkg::*;
#(
  parameter int W      = 16,
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_en,
  input logic [1:0]          xfer_mode,
  input logic                wr_en,
  input logic [3:0]          wr_addr,
  input logic [W-1:0]        wr_data,
  input logic [W-1:0]        count_o,
  input logic [W-1:0]        peak_o,
  input logic                cmp_flag,
  input logic [NUM_CH*W-1:0] duty_o,
  input logic                dir_up,
  input logic [NUM_CH*W-1:0] buf_flat
);
  // R1: every enabled step moves the count by exactly one
  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> (count_o == $past(count_o) + 1'b1) || (count_o == $past(count_o) - 1'b1));

  // R2: disabled counter holds its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count_o));

  // R3: rising step out of m sets the flag
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dir_up && count_o == peak_o) |=> cmp_flag);

  // R4: transfer copies buffers at the peak event
  p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dir_up && count_o == peak_o && xfer_mode == XFER_ON) |=> (duty_o == $past(buf_flat)));

  // R5: no active value moves while descending
  p_no_xfer_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_up |=> $stable(duty_o));

  // R6: a clear with no competing event leaves the flag low
  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADDR_STAT) && !wr_data[0] && !(cnt_en && count_o == peak_o))
      |=> !cmp_flag);
endmodule

bind tri_pwm_counter tpc_checker #(.W(W), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .xfer_mode (xfer_mode),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .count_o   (count_o),
  .peak_o    (peak_o),
  .cmp_flag  (cmp_flag),
  .duty_o    (duty_o),
  .dir_up    (dir_up),
  .buf_flat  (buf_flat)
);

// File: tb/sim_tri_pwm_counter.sv
module sim_tri_pwm_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic [1:0]    xfer_mode = 2'b00;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [3:0]    rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic [W-1:0]  count_o;
  logic [W-1:0]  peak_o;
  logic          cmp_flag;
  logic [NC*W-1:0] duty_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_pwm_counter #(.W(W), .NUM_CH(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .xfer_mode(xfer_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count_o(count_o),
    .peak_o(peak_o), .cmp_flag(cmp_flag), .duty_o(duty_o)
  );

  // {enable, expected count after the edge, expected flag}; peak = 3
  localparam logic [9:0] VEC [12] = '{
    {1'b1, 8'd1, 1'b0}, {1'b1, 8'd2, 1'b0}, {1'b1, 8'd3, 1'b0},
    {1'b1, 8'd4, 1'b1}, {1'b0, 8'd4, 1'b1}, {1'b1, 8'd3, 1'b1},
    {1'b1, 8'd2, 1'b1}, {1'b1, 8'd1, 1'b1}, {1'b1, 8'd0, 1'b1},
    {1'b0, 8'd0, 1'b1}, {1'b1, 8'd1, 1'b1}, {1'b1, 8'd2, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic step(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 count", int'(count_o), 0);
    check("R12 flag", int'(cmp_flag), 0);
    check("R12 duty", int'(duty_o), 0);
    rd(0, v); check("R12 peak", v, 0);

    wr(0, 3); wr(4, 10); wr(5, 20); wr(6, 30);
    xfer_mode = 2'b11;

    // table walk: R1 R2 R3 R7
    for (int i = 0; i < 12; i++) begin
      cnt_en = VEC[i][9];
      @(negedge clk);
      cnt_en = 1'b0;
      check($sformatf("R1/R2 count step %0d", i), int'(count_o), int'(VEC[i][8:1]));
      check($sformatf("R3 flag step %0d", i), int'(cmp_flag), int'(VEC[i][0]));
      if (i == 3) begin
        check("R4 duty ch0", int'(duty_o[7:0]), 10);
        check("R4 duty ch1", int'(duty_o[15:8]), 20);
        check("R4 duty ch2", int'(duty_o[23:16]), 30);
      end
    end

    // count = 2 rising; new buffers, clear flag
    wr(4, 11); wr(5, 21); wr(6, 31);
    wr(1, 0);
    check("R6 clear", int'(cmp_flag), 0);
    step(2);
    check("R1 peak overshoot", int'(count_o), 4);
    check("R3 set at m+1", int'(cmp_flag), 1);
    check("R4 ch0", int'(duty_o[7:0]), 11);
    check("R4 ch2", int'(duty_o[23:16]), 31);

    wr(4, 12); wr(5, 22); wr(6, 32);
    rd(4, v); check("R8 buffer readback", v, 12);
    rd(8, v); check("R8 active readback", v, 11);
    check("R8 active unchanged", int'(duty_o[15:8]), 21);
    wr(1, 0);
    step(2);
    check("R5 count down", int'(count_o), 2);
    check("R3 no set downward", int'(cmp_flag), 0);
    check("R5 no transfer downward", int'(duty_o[7:0]), 11);
    step(2);
    check("R7 reach zero", int'(count_o), 0);
    step(1);
    check("R7 turn up", int'(count_o), 1);
    rd(2, v); check("R13 count read", v, 1);
    rd(15, v); check("R13 unmapped", v, 0);

    // R9 other mode: flag but no copy
    xfer_mode = 2'b01;
    step(3);
    check("R9 count", int'(count_o), 4);
    check("R9 flag", int'(cmp_flag), 1);
    check("R9 no copy", int'(duty_o[7:0]), 11);

    // R6 clear and write-1 ignore
    wr(1, 0);
    check("R6 clear again", int'(cmp_flag), 0);
    wr(1, 1);
    check("R6 write one ignored", int'(cmp_flag), 0);
    rd(1, v); check("R6 status read", v, 0);

    // descend and climb back to m=3
    step(7);
    check("R7 back at m", int'(count_o), 3);
    check("R3 flag held low", int'(cmp_flag), 0);

    // R10 clear and event on the same edge
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = '0;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    check("R10 set wins", int'(cmp_flag), 1);
    check("R10 count", int'(count_o), 4);

    // R11 peak saturation
    wr(0, 255);
    rd(0, v); check("R11 saturate", v, 254);
    check("R11 peak port", int'(peak_o), 254);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule